// File: doc/BRIEF.md
# Coupled Sine-Cosine Recursive Oscillator

This block makes a pair of quadrature samples, a sine and a cosine, at one frequency fixed at build time. There is no phase accumulator and no table. Two registers hold the present sine and cosine values. On every enabled clock, each value moves by an increment: the other value times a constant coefficient `k`. Two constant-coefficient multipliers form the two cross terms.

The update is the modified coupled form. The cosine is advanced first. The sine is then advanced from the new cosine. This keeps the orbit closed, so the amplitude neither grows nor decays apart from rounding. The coefficient is `k = COEF / 2^COEF_W`, with `k ≈ 2·sin(π·f/fs)`. The default `COEF = 25726` with `COEF_W = 18` gives a period of 64 samples.

The amplitude is reloaded on demand through `init_i`. This clears any drift that rounding has built up, or starts a new burst at a different level.

Top module: `coupled_osc`

## Requirements
- R1: While `rst_ni` is low, and after it rises with no other stimulus, `cos_o` equals the parameter `RST_AMP` (default 16000) and `sin_o` equals 0.
- R2: A clock edge with `init_i` high loads `cos_o = amp_i` and `sin_o = 0`. This takes priority over `en_i`.
- R3: A clock edge with both `en_i` and `init_i` low leaves `sin_o` and `cos_o` unchanged.
- R4: A clock edge with `en_i` high and `init_i` low sets the new cosine to `c' = c − m(s)`. Here `s` and `c` are the old outputs, and `m(x) = floor((x·COEF + 2^(COEF_W−1)) / 2^COEF_W)`, which is the product rounded half up.
- R5: On that same edge the new sine is `s' = s + m(c')`. It uses the new cosine `c'` from R4.
- R6: Every rounded product differs from the exact `x·COEF/2^COEF_W` by more than −1/2 and by at most +1/2.
- R7: With the default coefficient and amplitude 16000, successive rising zero crossings of `sin_o` lie 63 to 65 enabled samples apart. A rising zero crossing is a previous sample below 0 followed by a sample of at least 0.
- R8: With amplitude 16000 over 20 periods, the per-period peak of each of `cos_o` and `sin_o` stays within 15840 to 16160.
- R9: The wide sums behind `c'` and `s'` always fit the signed `DW`-bit output range for amplitudes up to `RST_AMP`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance one sample on this clock |
| init_i | input | 1 | Reload the state from `amp_i` |
| amp_i | input | DW (16) | Signed amplitude loaded into the cosine |
| sin_o | output | DW (16) | Signed sine sample |
| cos_o | output | DW (16) | Signed cosine sample |

## Verification
Every result is due one clock edge after the stimulus that causes it. The outputs are the state registers themselves, and both multipliers and adders sit ahead of those registers in the same cycle. The bench changes inputs on the falling edge and samples 1 ns after the next rising edge. Each sample is compared with a bench model of R4 and R5 that was stepped once for that same edge. The period and peak checks count only enabled edges, so gaps in `en_i` do not shift the expected count.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int DW_DEF   = 16;
  localparam int KW_DEF   = 18;
  localparam int COEF_DEF = 25726;  // 2*sin(pi/64) * 2^18
  localparam int AMP_DEF  = 16000;
endpackage

// File: rtl/osc_cmul.sv
module osc_cmul #(
  parameter int DW    = osc_pkg::DW_DEF,
  parameter int KW    = osc_pkg::KW_DEF,
  parameter int COEF  = osc_pkg::COEF_DEF,
  parameter bit ROUND = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW:0]   y_o
);
  localparam int PW = DW + KW + 2;
  localparam logic signed [PW-1:0] C_S  = PW'(COEF);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (KW - 1);

  logic signed [PW-1:0] prod, biased;

  assign prod = PW'(x_i) * C_S;

  generate
    if (ROUND) begin : g_rnd
      assign biased = prod + HALF;
    end else begin : g_trunc
      assign biased = prod;
    end
  endgenerate

  assign y_o = (DW+1)'(biased >>> KW);

  logic signed [PW-1:0] err;
  assign err = (PW'(y_o) <<< KW) - prod;

  // R6
  rounding_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ROUND || ((err > -HALF) && (err <= HALF)));
endmodule

// File: rtl/osc_core.sv
module osc_core #(
  parameter int DW      = osc_pkg::DW_DEF,
  parameter int RST_AMP = osc_pkg::AMP_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 init_i,
  input  logic signed [DW-1:0] amp_i,
  input  logic signed [DW:0]   m_sin_i,
  input  logic signed [DW:0]   m_cos_i,
  output logic signed [DW-1:0] cos_nx_o,
  output logic signed [DW-1:0] sin_q_o,
  output logic signed [DW-1:0] cos_q_o
);
  localparam int SW = DW + 2;
  localparam logic signed [SW-1:0] MAXV = SW'((1 <<< (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -SW'(1 <<< (DW - 1));

  logic signed [SW-1:0] cos_w, sin_w;
  logic signed [DW-1:0] sin_nx;

  // cosine first, sine from the new cosine
  assign cos_w    = SW'(cos_q_o) - SW'(m_sin_i);
  assign cos_nx_o = DW'(cos_w);
  assign sin_w    = SW'(sin_q_o) + SW'(m_cos_i);
  assign sin_nx   = DW'(sin_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_q_o <= DW'(RST_AMP);
      sin_q_o <= '0;
    end else if (init_i) begin
      cos_q_o <= amp_i;
      sin_q_o <= '0;
    end else if (en_i) begin
      cos_q_o <= cos_nx_o;
      sin_q_o <= sin_nx;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !init_i) |-> (cos_w <= MAXV && cos_w >= MINV &&
                           sin_w <= MAXV && sin_w >= MINV));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !init_i) |=> ($stable(sin_q_o) && $stable(cos_q_o)));
endmodule

// File: rtl/coupled_osc.sv
module coupled_osc #(
  parameter int DW      = osc_pkg::DW_DEF,
  parameter int COEF_W  = osc_pkg::KW_DEF,
  parameter int COEF    = osc_pkg::COEF_DEF,
  parameter int RST_AMP = osc_pkg::AMP_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 init_i,
  input  logic signed [DW-1:0] amp_i,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o
);
  logic signed [DW:0]   m_sin, m_cos;
  logic signed [DW-1:0] cos_nx;

  osc_cmul #(.DW(DW), .KW(COEF_W), .COEF(COEF), .ROUND(1'b1)) u_mul_s (
    .clk_i(clk_i), .rst_ni(rst_ni), .x_i(sin_o), .y_o(m_sin)
  );

  osc_cmul #(.DW(DW), .KW(COEF_W), .COEF(COEF), .ROUND(1'b1)) u_mul_c (
    .clk_i(clk_i), .rst_ni(rst_ni), .x_i(cos_nx), .y_o(m_cos)
  );

  osc_core #(.DW(DW), .RST_AMP(RST_AMP)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .init_i(init_i),
    .amp_i(amp_i), .m_sin_i(m_sin), .m_cos_i(m_cos),
    .cos_nx_o(cos_nx), .sin_q_o(sin_o), .cos_q_o(cos_o)
  );

  // R2
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (sin_o == '0 && cos_o == $past(amp_i)));

  // R4
  cos_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !init_i) |=> (cos_o == DW'($past(cos_o) - $past(m_sin))));

  // R5
  sin_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !init_i) |=> (sin_o == DW'($past(sin_o) + $past(m_cos))));
endmodule

// File: tb/tb_coupled_osc.sv
`timescale 1ns/1ps
module tb_coupled_osc;
  localparam int DW = 16;
  localparam int KW = 18;
  localparam int K  = 25726;
  localparam int RA = 16000;
  localparam int NV = 6;
  localparam int AMP_TAB  [NV] = '{16000, -12000, 1, -1, 32, 9000};
  localparam int STEP_TAB [NV] = '{70, 50, 20, 20, 30, 66};

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, init = 1'b0;
  logic signed [DW-1:0] amp = '0, sin_v, cos_v;
  int n_chk = 0, n_fail = 0;
  longint ms, mc;

  always #2 clk = ~clk;

  coupled_osc #(.DW(DW), .COEF_W(KW), .COEF(K), .RST_AMP(RA)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .init_i(init),
    .amp_i(amp), .sin_o(sin_v), .cos_o(cos_v)
  );

  function automatic longint mr(longint x);
    return (x * K + (64'sd1 <<< (KW - 1))) >>> KW;
  endfunction

  task automatic model_step();
    mc = mc - mr(ms);
    ms = ms + mr(mc);
  endtask

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(logic e, logic i, int a);
    @(negedge clk);
    en = e; init = i; amp = DW'(a);
    @(posedge clk); #1;
  endtask

  initial begin
    #150000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int prev_s, last_x, cnt, pmax_c, pmax_s, nper;
    #10;
    chk("R1 cos in reset", cos_v, RA);
    chk("R1 sin in reset", sin_v, 0);
    @(negedge clk); rst_n = 1'b1;
    tick(1'b0, 1'b0, 0);
    chk("R1 cos after reset", cos_v, RA);
    chk("R1 sin after reset", sin_v, 0);

    // vector table: reload then exact steps against model (R2, R4, R5)
    for (int v = 0; v < NV; v++) begin
      tick(1'b0, 1'b1, AMP_TAB[v]);
      chk("R2 cos load", cos_v, AMP_TAB[v]);
      chk("R2 sin load", sin_v, 0);
      mc = AMP_TAB[v]; ms = 0;
      for (int s = 0; s < STEP_TAB[v]; s++) begin
        tick(1'b1, 1'b0, 0);
        model_step();
        chk("R4 cos step", cos_v, mc);
        chk("R5 sin step", sin_v, ms);
      end
    end

    // R3: idle edges hold state
    for (int s = 0; s < 5; s++) begin
      tick(1'b0, 1'b0, 123);
      chk("R3 cos hold", cos_v, mc);
      chk("R3 sin hold", sin_v, ms);
    end

    // R2: init wins over enable
    tick(1'b1, 1'b1, -500);
    chk("R2 priority cos", cos_v, -500);
    chk("R2 priority sin", sin_v, 0);

    // R7/R8: long run with enable gaps
    tick(1'b0, 1'b1, 16000);
    mc = 16000; ms = 0;
    prev_s = 0; last_x = -1; cnt = 0; pmax_c = 0; pmax_s = 0; nper = 0;
    for (int s = 0; s < 64 * 20; s++) begin
      if (s % 7 == 3) tick(1'b0, 1'b0, 0);
      tick(1'b1, 1'b0, 0);
      model_step();
      if (cos_v != mc || sin_v != ms) chk("R5 long run", sin_v, ms);
      cnt++;
      if (int'(cos_v) > pmax_c) pmax_c = cos_v;
      if (int'(sin_v) > pmax_s) pmax_s = sin_v;
      if (prev_s < 0 && int'(sin_v) >= 0) begin
        if (last_x >= 0) begin
          if (cnt - last_x < 63 || cnt - last_x > 65)
            chk("R7 period", cnt - last_x, 64);
          else chk("R7 period", 64, 64);
          nper++;
          if (pmax_c < 15840 || pmax_c > 16160) chk("R8 cos peak", pmax_c, 16000);
          else chk("R8 cos peak", 16000, 16000);
          if (pmax_s < 15840 || pmax_s > 16160) chk("R8 sin peak", pmax_s, 16000);
          else chk("R8 sin peak", 16000, 16000);
        end
        last_x = cnt; pmax_c = 0; pmax_s = 0;
      end
      prev_s = sin_v;
    end
    chk("R7 periods seen", nper >= 18, 1);

    // R1: async reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 async cos", cos_v, RA);
    chk("R1 async sin", sin_v, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule